// File: doc/BRIEF.md
# Fractional-Order Binomial Weight Generator

This block builds, on chip, the weight sequence of a truncated Grünwald–Letnikov fractional operator. Software or a controller gives it a signed fixed-point order and a window length, then pulses a start request. The block keeps the order in a register and writes weight zero, which is always one. After that it applies the first-order recursion and produces one further weight per clock cycle. Each weight goes into an internal coefficient table, indexed by its position in the window. The same hardware serves differentiation (positive order) and integration (negative order).

A downstream multiply-accumulate stage reads the finished table through a registered read port, one index per cycle. A one-cycle completion pulse marks the end of each run. While a run is in progress the busy output is high and new start requests are not accepted. There is no divider: the factor (q+1)/j is formed by multiplying by a reciprocal of j. That reciprocal comes from a constant table filled in at elaboration.

Top module: `fracw_gen`

## Requirements
- R1: `order_in` is a signed two's-complement order with 12 fractional bits, so 0x1000 is +1.0 and 0xF000 is -1.0. The valid range is [-1.0, +1.0]. The order and the window length are captured on the clock edge where `start` is accepted, and they stay unchanged until the run completes.
- R2: Table entry 0 of every run holds exactly 1.0. Weights are signed 32-bit values with 24 fractional bits, so 1.0 is 0x01000000.
- R3: For j >= 1, the weight is computed in integer arithmetic as follows. r = floor(2^20 / j). f = floor((order_in + 4096) * r / 2^8). c = 2^24 - f. w_j = floor(c * w_{j-1} / 2^24). Every floor rounds toward minus infinity. Two consequences: order -1.0 gives every entry 1.0, and order +1.0 gives 1.0, -1.0, then zeros.
- R4: Let the accepting edge be E0. Entry 0 is written at edge E1 and entry j at edge E(1+j). `done` is high for exactly one cycle, the one that follows the edge writing the last entry L.
- R5: A `start` that arrives while `busy` is high is ignored. It changes neither the order in use, the window length, the completion time nor the table contents.
- R6: A window length of 0 writes only entry 0. All other table entries keep their earlier values.
- R7: A requested window length above MAX_LEN (1024) is treated as MAX_LEN. No entry beyond index MAX_LEN is ever written.
- R8: `rd_data` returns the table entry addressed by `rd_idx` one clock edge later. An index above MAX_LEN reads as 0.
- R9: After reset, `busy` and `done` are low. `busy` is high from the cycle after acceptance until the last write. A `start` given in the cycle where `done` is high is accepted and begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a generation run |
| order_in | input | 16 | Signed fractional order, 12 fractional bits |
| len_in | input | 11 | Window length L (highest index written) |
| rd_idx | input | 11 | Coefficient table read index |
| busy | output | 1 | Generation run in progress |
| done | output | 1 | One-cycle pulse after the last entry is written |
| rd_data | output | 32 | Registered table read data, 24 fractional bits |

## Verification
The completion pulse and the acceptance of a fresh request can fall in the same cycle, because the controller is already idle while `done` is high. The bench drives `start` with a new order in exactly the cycle where it sees `done`. It then judges the outcome by two things: the second run's completion latency, and a full table read-back that must match the second order's recursion. A request raised in the middle of a run is checked the opposite way. It must leave both the completion time and the table of the first order unchanged.

// File: rtl/fracw_pkg.sv
package fracw_pkg;

    localparam int Q_W    = 16;
    localparam int Q_FRAC = 12;
    localparam int W_W    = 32;
    localparam int W_FRAC = 24;
    localparam int R_FRAC = 20;
    localparam int R_W    = R_FRAC + 1;
    localparam int QP_W   = Q_W + 1;
    localparam int F_W    = QP_W + R_W + 1;
    localparam int F_SHIFT = Q_FRAC + R_FRAC - W_FRAC;
    localparam int P_W    = 2 * W_W;

    typedef logic signed [Q_W-1:0] order_t;
    typedef logic signed [W_W-1:0] weight_t;

    localparam weight_t W_ONE = weight_t'(64'sd1 <<< W_FRAC);
    localparam logic signed [QP_W-1:0] QP_ONE = QP_W'(1 << Q_FRAC);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2
    } gen_state_e;

    typedef struct packed {
        logic    en;
        weight_t data;
    } wr_req_t;

    function automatic logic signed [QP_W-1:0] order_plus_one(input order_t q);
        return QP_W'(signed'({q[Q_W-1], q})) + QP_ONE;
    endfunction

endpackage

// File: rtl/fracw_recip_rom.sv
module fracw_recip_rom #(
    parameter int MAX_LEN = 1024,
    parameter int IDX_W   = $clog2(MAX_LEN + 1)
) (
    input  logic [IDX_W-1:0]             idx,
    output logic [fracw_pkg::R_W-1:0]    recip
);
    import fracw_pkg::*;

    logic [R_W-1:0] tbl [0:MAX_LEN];

    assign tbl[0] = '0;
    for (genvar g = 1; g <= MAX_LEN; g++) begin : g_entry
        localparam int RV = (1 << R_FRAC) / g;
        assign tbl[g] = R_W'(RV);
    end

    always_comb begin
        if (idx <= IDX_W'(MAX_LEN)) recip = tbl[idx];
        else                        recip = '0;
    end

endmodule

// File: rtl/fracw_step.sv
module fracw_step (
    input  fracw_pkg::order_t           q,
    input  logic [fracw_pkg::R_W-1:0]   recip,
    input  fracw_pkg::weight_t          w_prev,
    output fracw_pkg::weight_t          w_next
);
    import fracw_pkg::*;

    logic signed [QP_W-1:0] qp1;
    logic signed [F_W-1:0]  f_full;
    logic signed [F_W-1:0]  f_q24;
    weight_t                coef;
    logic signed [P_W-1:0]  prod;
    logic signed [P_W-1:0]  prod_sh;

    always_comb begin
        qp1     = order_plus_one(q);
        f_full  = F_W'(qp1) * F_W'(signed'({1'b0, recip}));
        f_q24   = f_full >>> F_SHIFT;
        coef    = W_ONE - weight_t'(f_q24);
        prod    = P_W'(coef) * P_W'(w_prev);
        prod_sh = prod >>> W_FRAC;
        w_next  = weight_t'(prod_sh);
    end

endmodule

// File: rtl/fracw_coef_ram.sv
module fracw_coef_ram #(
    parameter int MAX_LEN = 1024,
    parameter int IDX_W   = $clog2(MAX_LEN + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  fracw_pkg::wr_req_t   wr,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [IDX_W-1:0]     rd_idx,
    output fracw_pkg::weight_t   rd_data
);
    import fracw_pkg::*;

    weight_t mem [0:MAX_LEN];

    always_ff @(posedge clk) begin
        if (wr.en && (wr_idx <= IDX_W'(MAX_LEN))) mem[wr_idx] <= wr.data;
    end

    always_ff @(posedge clk) begin
        if (rst)                                rd_data <= '0;
        else if (rd_idx <= IDX_W'(MAX_LEN))     rd_data <= mem[rd_idx];
        else                                    rd_data <= '0;
    end

    AST_W0_ONE: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr_idx == '0) |-> (wr.data == W_ONE)); // R2

    AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> (wr_idx <= IDX_W'(MAX_LEN))); // R7

endmodule

// File: rtl/fracw_ctrl.sv
module fracw_ctrl #(
    parameter int MAX_LEN = 1024,
    parameter int IDX_W   = $clog2(MAX_LEN + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  fracw_pkg::order_t    order_in,
    input  logic [IDX_W-1:0]     len_in,
    output fracw_pkg::order_t    q_r,
    output logic [IDX_W-1:0]     len_r,
    output logic [IDX_W-1:0]     wr_idx,
    output logic                 wr_en,
    output logic                 load,
    output logic                 busy,
    output logic                 done
);
    import fracw_pkg::*;

    localparam logic [IDX_W-1:0] LEN_CAP = IDX_W'(MAX_LEN);

    gen_state_e       state;
    logic [IDX_W-1:0] j_r;
    logic [IDX_W-1:0] len_clamped;

    assign len_clamped = (len_in > LEN_CAP) ? LEN_CAP : len_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            q_r   <= '0;
            len_r <= '0;
            j_r   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        q_r   <= order_in;
                        len_r <= len_clamped;
                        state <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    j_r <= IDX_W'(1);
                    if (len_r == '0) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        state <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (j_r == len_r) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        j_r <= j_r + IDX_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign load   = (state == ST_LOAD);
    assign busy   = (state != ST_IDLE);
    assign wr_en  = (state != ST_IDLE);
    assign wr_idx = load ? '0 : j_r;

    AST_ORDER_HELD: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(q_r) && $stable(len_r))); // R1

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(q_r)); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R4

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !load) |-> (wr_idx == $past(wr_idx) + IDX_W'(1))); // R4

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(wr_en) && $past(wr_idx) == len_r)); // R4

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_idx <= len_r && len_r <= LEN_CAP)); // R7

endmodule

// File: rtl/fracw_gen.sv
module fracw_gen #(
    parameter int MAX_LEN = 1024,
    parameter int IDX_W   = $clog2(MAX_LEN + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    input  logic [fracw_pkg::Q_W-1:0]   order_in,
    input  logic [IDX_W-1:0]            len_in,
    input  logic [IDX_W-1:0]            rd_idx,
    output logic                        busy,
    output logic                        done,
    output logic [fracw_pkg::W_W-1:0]   rd_data
);
    import fracw_pkg::*;

    order_t           q_r;
    logic [IDX_W-1:0] len_r;
    logic [IDX_W-1:0] wr_idx;
    logic             wr_en;
    logic             load;
    logic [R_W-1:0]   recip;
    weight_t          w_prev;
    weight_t          w_next;
    wr_req_t          wr;
    weight_t          rd_w;

    fracw_ctrl #(.MAX_LEN(MAX_LEN), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .order_in(order_t'(order_in)),
        .len_in(len_in), .q_r(q_r), .len_r(len_r), .wr_idx(wr_idx),
        .wr_en(wr_en), .load(load), .busy(busy), .done(done)
    );

    fracw_recip_rom #(.MAX_LEN(MAX_LEN), .IDX_W(IDX_W)) u_rom (
        .idx(wr_idx), .recip(recip)
    );

    fracw_step u_step (
        .q(q_r), .recip(recip), .w_prev(w_prev), .w_next(w_next)
    );

    always_comb begin
        wr.en   = wr_en;
        wr.data = load ? W_ONE : w_next;
    end

    always_ff @(posedge clk) begin
        if (rst)        w_prev <= '0;
        else if (wr_en) w_prev <= wr.data;
    end

    fracw_coef_ram #(.MAX_LEN(MAX_LEN), .IDX_W(IDX_W)) u_ram (
        .clk(clk), .rst(rst), .wr(wr), .wr_idx(wr_idx),
        .rd_idx(rd_idx), .rd_data(rd_w)
    );

    assign rd_data = rd_w;

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
        done |-> !$past(load) || !busy); // R9

endmodule

// File: tb/sim_fracw_gen.sv
module sim_fracw_gen;

    localparam int MAXL = 1024;
    localparam int IW   = 11;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [15:0]   order_in = '0;
    logic [IW-1:0] len_in = '0;
    logic [IW-1:0] rd_idx = '0;
    logic          busy, done;
    logic [31:0]   rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    longint expw [0:MAXL];

    always #10 clk = ~clk;

    fracw_gen u0 (
        .clk(clk), .rst(rst), .start(start), .order_in(order_in),
        .len_in(len_in), .rd_idx(rd_idx), .busy(busy), .done(done),
        .rd_data(rd_data)
    );

    localparam int NV = 6;
    localparam logic [15:0] VQ  [NV] = '{16'h0000, 16'h1000, 16'hF000, 16'h0666, 16'hF19A, 16'h0E66};
    localparam int          VL  [NV] = '{5, 4, 20, 32, 1024, 17};
    localparam logic [31:0] VW1 [NV] = '{32'h00000000, 32'hFF000000, 32'h01000000,
                                         32'hFF99A000, 32'h00E66000, 32'hFF19A000};

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void build_model(input logic [15:0] q, input int len);
        longint w, r, f, c, qs;
        qs = longint'($signed(q));
        w = 64'sd1 <<< 24;
        expw[0] = w;
        for (int j = 1; j <= len; j++) begin
            r = (64'sd1 <<< 20) / j;
            f = ((qs + 4096) * r) >>> 8;
            c = (64'sd1 <<< 24) - f;
            w = (c * w) >>> 24;
            expw[j] = w;
        end
    endfunction

    // called and returns at a negedge
    task automatic run_gen(input logic [15:0] q, input int len, output int lat);
        start = 1'b1; order_in = q; len_in = IW'(len);
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 3000) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic rd(input int idx, output logic [31:0] d);
        rd_idx = IW'(idx);
        @(negedge clk);
        d = rd_data;
    endtask

    task automatic check_table(input int len, input string req);
        logic [31:0] d;
        int bad = 0;
        longint first_a = 0, first_e = 0;
        for (int i = 0; i <= len; i++) begin
            rd(i, d);
            if (longint'($signed(d)) != expw[i] && bad == 0) begin
                first_a = longint'($signed(d)); first_e = expw[i];
            end
            if (longint'($signed(d)) != expw[i]) bad++;
        end
        check(bad == 0, req, first_a, first_e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        int lat, lat2;
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check(busy == 1'b0, "R9 busy after reset", busy, 0);
        check(done == 1'b0, "R9 done after reset", done, 0);

        // vector table: R1 R2 R3 R4
        for (int v = 0; v < NV; v++) begin
            run_gen(VQ[v], VL[v], lat);
            check(lat == VL[v] + 2, "R4 done latency", lat, VL[v] + 2);
            @(negedge clk);
            check(done == 1'b0, "R4 done single cycle", done, 0);
            build_model(VQ[v], VL[v]);
            rd(0, d);
            check(d == 32'h01000000, "R2 entry0", d, 32'h01000000);
            rd(1, d);
            check(d == VW1[v], "R3 entry1", longint'($signed(d)), longint'($signed(VW1[v])));
            check_table(VL[v], "R3 full table");
        end

        // R1/R5: start during run ignored
        run_gen(16'h0666, 8, lat);
        begin
            start = 1'b1; order_in = 16'h0666; len_in = 11'd8;
            @(negedge clk); start = 1'b0;
            repeat (3) @(negedge clk);
            check(busy == 1'b1, "R9 busy mid-run", busy, 1);
            start = 1'b1; order_in = 16'hF000; len_in = 11'd3;
            @(negedge clk); start = 1'b0;
            lat = 5;
            while (!done && lat < 3000) begin @(negedge clk); lat++; end
            check(lat == 10, "R5 latency unchanged", lat, 10);
            @(negedge clk);
            check(busy == 1'b0, "R5 no extra run", busy, 0);
            build_model(16'h0666, 8);
            check_table(8, "R5 R1 table keeps first order");
        end

        // R6: L=0 keeps other entries
        run_gen(16'hF000, 3, lat);
        run_gen(16'h0000, 0, lat);
        check(lat == 2, "R6 latency L0", lat, 2);
        rd(0, d);
        check(d == 32'h01000000, "R6 entry0", d, 32'h01000000);
        rd(1, d);
        check(d == 32'h01000000, "R6 entry1 untouched", d, 32'h01000000);

        // R7: clamp
        run_gen(16'hF000, 2047, lat);
        check(lat == MAXL + 2, "R7 clamped latency", lat, MAXL + 2);
        rd(MAXL, d);
        check(d == 32'h01000000, "R7 last entry", d, 32'h01000000);

        // R8: out-of-range read
        rd(2000, d);
        check(d == 32'h0, "R8 out of range read", d, 0);

        // R9: start in the done cycle
        run_gen(16'h1000, 2, lat);
        run_gen(16'hF000, 2, lat2);
        check(lat2 == 4, "R9 back-to-back latency", lat2, 4);
        build_model(16'hF000, 2);
        check_table(2, "R9 back-to-back table");

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule